// File: doc/BRIEF.md
# Supply Threshold Trim Programming Sequencer

This block sits behind the byte-write path of a serial memory slave. The slave front end reports each completed data byte as an address/data pair, and it reports the stop condition that closes a transaction. Every such byte is forwarded one cycle later to the memory array write port, unchanged. When the high-voltage-present flag is raised, a write of one of four command values to the fixed command address arms a trim operation. The flag comes from a detector on the reset pin. The trim operation acts on one of two digital trim registers: the primary supply threshold or the secondary supply threshold.

The armed operation runs on the next stop condition. A raise operation loads an externally applied level code, but only when that code is strictly above the current trim value. A clear operation forces the trim to the floor value. After the operation, the sequencer stays busy and ignores every further command until the high-voltage flag drops. It then returns to idle. This gives a lower threshold through a clear followed by a raise, run in two separate high-voltage sessions.

Top module: `trim_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `pri_trim` equals `PRI_INIT` (default 140), `sec_trim` equals `SEC_INIT` (default 100), `trim_busy` is 0 and `mem_we` is 0.
- R2: Every byte with `wr_en` high appears on `mem_we`/`mem_addr`/`mem_wdata` one cycle later with the same address and data, including command bytes and bytes written without high voltage. `mem_we` is 0 in the cycle after a cycle with no write.
- R3: While `hv_present` is 0, no write or stop changes either trim, and `trim_busy` stays 0.
- R4: With `hv_present` high and the sequencer idle, a write to address 0 arms an operation, and `trim_busy` is 1 from the next cycle. The data values are 8'h01 (raise primary), 8'h0D (raise secondary), 8'h03 (clear primary) and 8'h0F (clear secondary). The trims do not change until a later `stop_evt`.
- R5: On `stop_evt` while a raise is armed, the target trim takes `level_code` only if `level_code` is strictly greater than its current value. Otherwise it is unchanged. The update is visible in the cycle after the stop.
- R6: On `stop_evt` while a clear is armed, the target trim becomes `FLOOR` (default 0) in the cycle after the stop.
- R7: With `hv_present` high, a write of any other data value to address 0, or any write to a nonzero address, arms nothing: `trim_busy` stays 0 and a following stop changes no trim.
- R8: Once armed or done, further command writes and stops change no trim until `hv_present` has dropped.
- R9: When `hv_present` is 0 at a clock edge, `trim_busy` is 0 after that edge. An operation armed but not yet triggered by a stop is discarded.
- R10: An operation changes only its own target trim. The other trim keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_present | input | 1 | High voltage detected on the reset pin |
| wr_en | input | 1 | One-cycle strobe: a data byte was accepted |
| wr_addr | input | AW (13) | Array address of the accepted byte |
| wr_data | input | 8 | Accepted data byte |
| stop_evt | input | 1 | One-cycle strobe: stop condition seen |
| level_code | input | TW (8) | Digitised level applied to the monitored supply |
| mem_we | output | 1 | Array write enable (registered) |
| mem_addr | output | AW (13) | Array write address |
| mem_wdata | output | 8 | Array write data |
| pri_trim | output | TW (8) | Primary threshold trim value |
| sec_trim | output | TW (8) | Secondary threshold trim value |
| trim_busy | output | 1 | A trim operation is armed or done, awaiting high-voltage removal |

## Verification
The assertions check these rules on every cycle:
- a raise never lowers a trim;
- a clear lands on the floor;
- a trim holds when no operation is applied;
- at most one trim is touched per cycle;
- an operation applies only with a stop under high voltage;
- busy drops after high voltage goes away;
- every write reaches the array port one cycle later.

The choice of operation, the ignoring of codes once busy, the discarding of an armed operation that has no stop, and the two-session lowering of a threshold come from sequences over many cycles. Only the bench scenarios, directed and random, show these.

// File: rtl/trim_pkg.sv
// Package: shared operation type and command byte decoding for the trim
// sequencer. Assumes command bytes are 8 bits wide.
package trim_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PRI_SET = 3'd1,
        OP_PRI_CLR = 3'd2,
        OP_SEC_SET = 3'd3,
        OP_SEC_CLR = 3'd4
    } trim_op_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_HOLD  = 2'd2
    } seq_state_t;

    localparam logic [7:0] CODE_PRI_SET = 8'h01;
    localparam logic [7:0] CODE_PRI_CLR = 8'h03;
    localparam logic [7:0] CODE_SEC_SET = 8'h0D;
    localparam logic [7:0] CODE_SEC_CLR = 8'h0F;

    // Map a data byte to the trim operation it requests (OP_NONE otherwise).
    function automatic trim_op_t byte_to_op(input logic [7:0] b);
        case (b)
            CODE_PRI_SET: byte_to_op = OP_PRI_SET;
            CODE_PRI_CLR: byte_to_op = OP_PRI_CLR;
            CODE_SEC_SET: byte_to_op = OP_SEC_SET;
            CODE_SEC_CLR: byte_to_op = OP_SEC_CLR;
            default:      byte_to_op = OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/trim_cmd_decode.sv
// Command decoder: classifies a completed byte write as a trim request.
// Assumes wr_en is a one-cycle strobe and the address is the array address
// of the byte just accepted. Purely combinational.
module trim_cmd_decode
    import trim_pkg::*;
#(
    parameter int AW       = 13,
    parameter int CMD_ADDR = 0
) (
    input  logic          hv_present,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output trim_op_t      req_op
);

    localparam logic [AW-1:0] CMD_ADDR_V = AW'(CMD_ADDR);

    logic addr_hit;

    // Address match against the fixed command location.
    always_comb addr_hit = (wr_addr == CMD_ADDR_V);

    // Qualify the data code with write strobe, address and high voltage.
    always_comb begin
        if (hv_present && wr_en && addr_hit) req_op = byte_to_op(wr_data);
        else                                 req_op = OP_NONE;
    end

endmodule

// File: rtl/trim_seq_fsm.sv
// Sequencer: arms on a qualified request, fires the armed operation on the
// next stop condition, then holds until high voltage is removed.
// Assumes stop_evt is a one-cycle strobe; loss of high voltage wins over all.
module trim_seq_fsm
    import trim_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hv_present,
    input  trim_op_t req_op,
    input  logic     stop_evt,
    output logic [1:0] apply_set,
    output logic [1:0] apply_clr,
    output logic     busy
);

    seq_state_t state_q;
    trim_op_t   op_q;
    logic       fire;

    // State and latched operation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_NONE;
        end else if (!hv_present) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_NONE;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (req_op != OP_NONE) begin
                        state_q <= SQ_ARMED;
                        op_q    <= req_op;
                    end
                end
                SQ_ARMED: begin
                    if (stop_evt) state_q <= SQ_HOLD;
                end
                SQ_HOLD:  state_q <= SQ_HOLD;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    // Operation fires on the stop that follows an armed request.
    always_comb fire = (state_q == SQ_ARMED) && stop_evt && hv_present;

    // Per-target strobes; index 0 is primary, 1 is secondary.
    always_comb begin
        apply_set[0] = fire && (op_q == OP_PRI_SET);
        apply_clr[0] = fire && (op_q == OP_PRI_CLR);
        apply_set[1] = fire && (op_q == OP_SEC_SET);
        apply_clr[1] = fire && (op_q == OP_SEC_CLR);
    end

    // Busy while an operation is pending or done and high voltage remains.
    always_comb busy = (state_q != SQ_IDLE);

    AST_IDLE_AFTER_HV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_present |=> !busy); // R9
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({apply_set, apply_clr})); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hv_present) |=> busy); // R8

endmodule

// File: rtl/trim_reg.sv
// One threshold trim register. A clear forces FLOOR; a raise loads the
// applied level only when it is strictly greater than the stored value.
// Assumes apply_set and apply_clr are never high together.
module trim_reg #(
    parameter int TW    = 8,
    parameter int INIT  = 140,
    parameter int FLOOR = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply_set,
    input  logic          apply_clr,
    input  logic [TW-1:0] level,
    output logic [TW-1:0] q
);

    localparam logic [TW-1:0] INIT_V  = TW'(INIT);
    localparam logic [TW-1:0] FLOOR_V = TW'(FLOOR);

    // Trim storage with raise-only and clear-to-floor updates.
    always_ff @(posedge clk) begin
        if (!rst_n)                         q <= INIT_V;
        else if (apply_clr)                 q <= FLOOR_V;
        else if (apply_set && (level > q))  q <= level;
    end

    AST_RAISE_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        apply_set |=> (q >= $past(q))); // R5
    AST_CLEAR_TO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        apply_clr |=> (q == FLOOR_V)); // R6
    AST_HOLD_WITHOUT_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply_set || apply_clr) |=> $stable(q)); // R3

endmodule

// File: rtl/trim_seq_top.sv
// Top: forwards every accepted byte to the array port and runs the trim
// sequencer on the two threshold registers. Assumes the front end delivers
// one byte per wr_en strobe and one stop_evt strobe per stop condition.
module trim_seq_top
    import trim_pkg::*;
#(
    parameter int AW       = 13,
    parameter int TW       = 8,
    parameter int CMD_ADDR = 0,
    parameter int PRI_INIT = 140,
    parameter int SEC_INIT = 100,
    parameter int FLOOR    = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_present,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          stop_evt,
    input  logic [TW-1:0] level_code,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [TW-1:0] pri_trim,
    output logic [TW-1:0] sec_trim,
    output logic          trim_busy
);

    localparam int NTRIM = 2;

    trim_op_t         req_op;
    logic [NTRIM-1:0] apply_set;
    logic [NTRIM-1:0] apply_clr;
    logic [TW-1:0]    trim_q [NTRIM];

    // Every accepted byte goes to the array, command or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr_en;
            if (wr_en) begin
                mem_addr  <= wr_addr;
                mem_wdata <= wr_data;
            end
        end
    end

    trim_cmd_decode #(.AW(AW), .CMD_ADDR(CMD_ADDR)) u_dec (
        .hv_present (hv_present),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .req_op     (req_op)
    );

    trim_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_present (hv_present),
        .req_op     (req_op),
        .stop_evt   (stop_evt),
        .apply_set  (apply_set),
        .apply_clr  (apply_clr),
        .busy       (trim_busy)
    );

    for (genvar g = 0; g < NTRIM; g++) begin : g_trim
        trim_reg #(
            .TW    (TW),
            .INIT  ((g == 0) ? PRI_INIT : SEC_INIT),
            .FLOOR (FLOOR)
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .apply_set (apply_set[g]),
            .apply_clr (apply_clr[g]),
            .level     (level_code),
            .q         (trim_q[g])
        );
    end

    // Named outputs for the two thresholds.
    always_comb begin
        pri_trim = trim_q[0];
        sec_trim = trim_q[1];
    end

    AST_WRITE_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_we && mem_addr == $past(wr_addr) && mem_wdata == $past(wr_data))); // R2
    AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !mem_we); // R2
    AST_APPLY_NEEDS_STOP_HV: assert property (@(posedge clk) disable iff (!rst_n)
        (|{apply_set, apply_clr}) |-> (stop_evt && hv_present && trim_busy)); // R4
    AST_QUIET_WITHOUT_HV: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_present |=> ($stable(pri_trim) && $stable(sec_trim))); // R3

endmodule

// File: tb/sim_trim_seq_top.sv
module sim_trim_seq_top;

    localparam int CLK_P = 10;
    localparam int AW = 13;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_present = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          stop_evt = 1'b0;
    logic [TW-1:0] level_code = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [TW-1:0] pri_trim, sec_trim;
    logic          trim_busy;

    int checks = 0;
    int errors = 0;

    // bench model
    int m_pri = 140, m_sec = 100, m_state = 0, m_op = 0;

    trim_seq_top u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 1 pri raise, 2 pri clear, 3 sec raise, 4 sec clear, 0 none
    function automatic int code_of(input logic [7:0] d);
        case (d)
            8'h01: return 1;
            8'h03: return 2;
            8'h0D: return 3;
            8'h0F: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int raised(input int cur, input int lv);
        return (lv > cur) ? lv : cur;
    endfunction

    task automatic step(input logic h, input logic we, input logic [AW-1:0] a,
                        input logic [7:0] d, input logic st, input logic [7:0] lv,
                        input string tag);
        @(negedge clk);
        hv_present = h; wr_en = we; wr_addr = a; wr_data = d;
        stop_evt = st; level_code = lv;
        @(posedge clk);
        if (!h) begin
            m_state = 0; m_op = 0;
        end else if (m_state == 0) begin
            if (we && a == 0 && code_of(d) != 0) begin
                m_state = 1; m_op = code_of(d);
            end
        end else if (m_state == 1 && st) begin
            case (m_op)
                1: m_pri = raised(m_pri, lv);
                2: m_pri = 0;
                3: m_sec = raised(m_sec, lv);
                4: m_sec = 0;
                default: ;
            endcase
            m_state = 2;
        end
        #(CLK_P/4);
        chk("R2 mem_we", mem_we, we);
        if (we) begin
            chk("R2 mem_addr", mem_addr, a);
            chk("R2 mem_wdata", mem_wdata, d);
        end
        chk({tag, " pri_trim"}, pri_trim, m_pri);
        chk({tag, " sec_trim"}, sec_trim, m_sec);
        chk({tag, " trim_busy"}, trim_busy, (m_state != 0) ? 1 : 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        chk("R1 pri_trim", pri_trim, 140);
        chk("R1 sec_trim", sec_trim, 100);
        chk("R1 trim_busy", trim_busy, 0);
        chk("R1 mem_we", mem_we, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: codes without high voltage
        step(0, 1, 0, 8'h03, 0, 8'd0, "R3");
        step(0, 0, 0, 8'h00, 1, 8'd0, "R3");
        chk("R3 pri unchanged", pri_trim, 140);

        // R4, R5, R8, R9: raise primary, ignore later code, drop HV
        step(1, 1, 0, 8'h01, 0, 8'd200, "R4");
        chk("R4 busy armed", trim_busy, 1);
        chk("R4 pri before stop", pri_trim, 140);
        step(1, 0, 0, 8'h00, 1, 8'd200, "R5");
        chk("R5 pri raised", pri_trim, 200);
        step(1, 1, 0, 8'h03, 0, 8'd0, "R8");
        step(1, 0, 0, 8'h00, 1, 8'd0, "R8");
        chk("R8 pri kept", pri_trim, 200);
        step(0, 0, 0, 8'h00, 0, 8'd0, "R9");
        chk("R9 busy low", trim_busy, 0);

        // R5: raise secondary with lower level has no effect
        step(1, 1, 0, 8'h0D, 0, 8'd50, "R5");
        step(1, 0, 0, 8'h00, 1, 8'd50, "R5");
        chk("R5 sec not lowered", sec_trim, 100);
        step(0, 0, 0, 8'h00, 0, 8'd0, "R9");

        // R6, R10: clear secondary then raise in next session
        step(1, 1, 0, 8'h0F, 1, 8'd0, "R6");
        step(1, 0, 0, 8'h00, 1, 8'd0, "R6");
        chk("R6 sec floor", sec_trim, 0);
        chk("R10 pri untouched", pri_trim, 200);
        step(0, 0, 0, 8'h00, 0, 8'd0, "R9");
        step(1, 1, 0, 8'h0D, 0, 8'd60, "R10");
        step(1, 0, 0, 8'h00, 1, 8'd60, "R10");
        chk("R10 sec lowered via clear", sec_trim, 60);
        chk("R10 pri untouched", pri_trim, 200);
        step(0, 0, 0, 8'h00, 0, 8'd0, "R9");

        // R7: wrong address / wrong data
        step(1, 1, 13'd1, 8'h01, 0, 8'd250, "R7");
        chk("R7 busy addr", trim_busy, 0);
        step(1, 1, 0, 8'h02, 0, 8'd250, "R7");
        chk("R7 busy data", trim_busy, 0);
        step(1, 0, 0, 8'h00, 1, 8'd250, "R7");
        chk("R7 pri kept", pri_trim, 200);

        // R9: armed then HV dropped before stop
        step(1, 1, 0, 8'h03, 0, 8'd0, "R9");
        step(0, 0, 0, 8'h00, 1, 8'd0, "R9");
        step(1, 0, 0, 8'h00, 1, 8'd0, "R9");
        chk("R9 discarded", pri_trim, 200);
        step(0, 0, 0, 8'h00, 0, 8'd0, "R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic h, we, st;
            logic [AW-1:0] a;
            logic [7:0] d;
            int sel;
            h  = ($urandom_range(0, 9) != 0);
            we = ($urandom_range(0, 1) == 1);
            st = ($urandom_range(0, 3) == 0);
            a  = ($urandom_range(0, 2) == 0) ? AW'($urandom) : '0;
            sel = $urandom_range(0, 5);
            case (sel)
                0: d = 8'h01;
                1: d = 8'h03;
                2: d = 8'h0D;
                3: d = 8'h0F;
                default: d = 8'($urandom);
            endcase
            step(h, we, a, d, st, 8'($urandom), "R5");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule